// File: doc/BRIEF.md
# Dual-Mode Delay Code Programming Port

This block holds the 8-bit code that sets a programmable delay core. The code can be written in two ways, and a mode pin picks which one is used. In bus mode an 8-bit word is copied while the enable pin is high and held while it is low, so enable can act as a level latch. In serial mode a three-wire port shifts a new word into a shadow register, most significant bit first. The active code changes only when enable drops. While bits shift in, the old shadow contents leave on the serial output in the same order. Several units can therefore be chained, and a unit's serial output can be looped back to its input to read the code without destroying it.

All pins are sampled on a system clock that is much faster than the serial clock. Each pin passes through a synchronizer, and the block detects edges on the synchronized copies. Whenever the active code takes a new value, the block issues a one-cycle strobe so the delay core can settle.

Top module: `dly_prog_port`

## Requirements
- R1: After reset the active code is zero, the strobe is low, the serial output enable is low, and the shadow register is zero. A first serial readback therefore returns eight zero bits.
- R2: With mode_par_i = 1 (bus mode) and en_i high, code_o follows par_code_i, delayed by the synchronizer stages plus one register.
- R3: In bus mode with en_i low, changes on par_code_i do not affect code_o. The value present just before enable fell is kept.
- R4: With mode_par_i = 0 (serial mode) and en_i high, each rising edge of sclk_i shifts sdi_i into bit 0 of the shadow register and moves the other bits one place toward bit 7. A word is sent bit 7 first. code_o does not change during the transfer.
- R5: In serial mode a falling edge of en_i copies the shadow register into code_o.
- R6: sdo_o always shows bit 7 of the shadow register. A transfer therefore returns the previous contents bit 7 first. sdo_oe_o is high only in serial mode while en_i is high.
- R7: code_upd_o pulses for one cycle each time code_o takes a different value. It stays low when a commit or bus load gives the same value, as in a looped-back readback.
- R8: In serial mode, sclk_i edges while en_i is low leave the shadow register unchanged.
- R9: If a rising sclk_i edge reaches the block in the same system cycle as the fall of en_i, no bit is shifted. The committed value is the shadow content from before that edge.
- R10: Two units chained from sdo_o to sdi_i receive 16 bits. The first eight bits end in the far unit and the last eight in the near unit.
- R11: A bus-mode load also writes the shadow register, so a later serial readback returns the active code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_par_i | input | 1 | 1 selects bus mode, 0 selects serial mode |
| en_i | input | 1 | Enable: bus transparency, or serial transfer window |
| sclk_i | input | 1 | Serial clock; shifts on the rising edge |
| sdi_i | input | 1 | Serial data in |
| par_code_i | input | CODE_W | Parallel code bus |
| code_o | output | CODE_W | Active delay code |
| code_upd_o | output | 1 | One-cycle strobe when code_o changes |
| sdo_o | output | 1 | Serial data out (shadow bit 7) |
| sdo_oe_o | output | 1 | Output enable for sdo_o |

## Verification
Two functions can meet in one system cycle: a serial shift and a commit, when a rising serial clock edge and the fall of enable reach the synchronizers together. The bench provokes this by moving both pins on the same clock edge after seven bits have been shifted. It then expects the committed code to be the shadow value after seven shifts, with no eighth bit taken. A second overlap is a readback that ends on the same value it started with. There the commit is judged by counting strobes, and the count must not change.

// File: rtl/dly_prog_pkg.sv
package dly_prog_pkg;
  parameter int unsigned CODE_W_DEF      = 8;
  parameter int unsigned SYNC_STAGES_DEF = 2;
  // mode, enable, serial clock, serial data
  localparam int unsigned CTL_PINS = 4;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } prog_mode_e;
endpackage

// File: rtl/dly_pin_sync.sv
module dly_pin_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= d_i;
    end
  end else begin : g_many
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[CHAIN_W-W-1:0], d_i};
    end
  end

  assign q_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/dly_edge_det.sv
module dly_edge_det #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  if (FALLING) begin : g_fall
    assign edge_o = prev_q & ~sig_i;
  end else begin : g_rise
    assign edge_o = ~prev_q & sig_i;
  end
endmodule

// File: rtl/dly_shadow_sreg.sv
module dly_shadow_sreg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] shadow_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], bit_i};
  end

  assign shadow_o = sh_q;
endmodule

// File: rtl/dly_code_reg.sv
module dly_code_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         par_load_i,
  input  logic [W-1:0] par_val_i,
  input  logic         commit_i,
  input  logic [W-1:0] commit_val_i,
  output logic [W-1:0] code_o,
  output logic         upd_o
);
  logic [W-1:0] code_q, code_nxt;
  logic         upd_q;

  always_comb begin
    code_nxt = code_q;
    if (par_load_i)    code_nxt = par_val_i;
    else if (commit_i) code_nxt = commit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_nxt;
      upd_q  <= (code_nxt != code_q);
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
endmodule

// File: rtl/dly_prog_port.sv
module dly_prog_port
  import dly_prog_pkg::*;
#(
  parameter int unsigned CODE_W      = CODE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_par_i,
  input  logic              en_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic [CODE_W-1:0] par_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_upd_o,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int unsigned SYNC_W = CODE_W + CTL_PINS;

  logic [SYNC_W-1:0] pins_raw, pins_syn;
  logic              mode_bit, en_s, sclk_s, sdi_s;
  logic [CODE_W-1:0] par_s;
  prog_mode_e        mode_s;
  logic              mode_ser_s;
  logic              en_fall, sclk_rise;
  logic              par_load, ser_shift, ser_commit;
  logic [CODE_W-1:0] shadow_q;

  assign pins_raw = {mode_par_i, en_i, sclk_i, sdi_i, par_code_i};

  dly_pin_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_raw),
    .q_o    (pins_syn)
  );

  assign {mode_bit, en_s, sclk_s, sdi_s, par_s} = pins_syn;
  assign mode_s     = prog_mode_e'(mode_bit);
  assign mode_ser_s = (mode_s == MODE_SERIAL);

  dly_edge_det #(.FALLING(1'b1)) u_en_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (en_s),
    .edge_o (en_fall)
  );

  dly_edge_det #(.FALLING(1'b0)) u_sclk_rise (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sclk_s),
    .edge_o (sclk_rise)
  );

  // shift needs enable still high; a coincident enable fall wins
  assign par_load   = (mode_s == MODE_PARALLEL) && en_s;
  assign ser_shift  = mode_ser_s && en_s && sclk_rise;
  assign ser_commit = mode_ser_s && en_fall;

  dly_shadow_sreg #(.W(CODE_W)) u_shadow (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (par_load),
    .load_val_i (par_s),
    .shift_i    (ser_shift),
    .bit_i      (sdi_s),
    .shadow_o   (shadow_q)
  );

  dly_code_reg #(.W(CODE_W)) u_code (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .par_load_i   (par_load),
    .par_val_i    (par_s),
    .commit_i     (ser_commit),
    .commit_val_i (shadow_q),
    .code_o       (code_o),
    .upd_o        (code_upd_o)
  );

  assign sdo_o    = shadow_q[CODE_W-1];
  assign sdo_oe_o = mode_ser_s && en_s;
endmodule

// File: rtl/dly_prog_port_chk.sv
module dly_prog_port_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mode_ser_s,
  input logic              en_s,
  input logic              en_fall,
  input logic              sclk_rise,
  input logic [CODE_W-1:0] shadow_q,
  input logic [CODE_W-1:0] code_o,
  input logic              code_upd_o,
  input logic              sdo_oe_o
);
  AST_HOLD_IN_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_s && en_s) |=> $stable(code_o)); // R4

  AST_SHIFT_TOWARD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_s && en_s && sclk_rise) |=> (shadow_q[CODE_W-1:1] == $past(shadow_q[CODE_W-2:0]))); // R4

  AST_COMMIT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_s && en_fall) |=> (code_o == $past(shadow_q))); // R5

  AST_OE_ONLY_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s |-> !sdo_oe_o); // R6

  AST_STROBE_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_upd_o |-> (code_o != $past(code_o))); // R7

  AST_NO_STROBE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_upd_o |-> $stable(code_o)); // R7

  AST_IDLE_SCLK_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_s && !en_s) |=> $stable(shadow_q)); // R8

  AST_FALL_BLOCKS_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ser_s && en_fall && sclk_rise) |=> $stable(shadow_q)); // R9
endmodule

bind dly_prog_port dly_prog_port_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_ser_s (mode_ser_s),
  .en_s       (en_s),
  .en_fall    (en_fall),
  .sclk_rise  (sclk_rise),
  .shadow_q   (shadow_q),
  .code_o     (code_o),
  .code_upd_o (code_upd_o),
  .sdo_oe_o   (sdo_oe_o)
);

// File: tb/dly_prog_port_tb.sv
module dly_prog_port_tb;
  localparam int TCLK = 10;
  localparam int W    = 8;
  localparam int SET  = 5;
  localparam int WD   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_par = 1'b0, en = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic [W-1:0] par = '0;
  logic [W-1:0] code_a, code_b;
  logic upd_a, upd_b, sdo_a, sdo_b, oe_a, oe_b;

  int n_chk = 0, n_fail = 0, upd_cnt = 0;

  always #(TCLK/2) clk = ~clk;

  dly_prog_port #(.CODE_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_par_i(mode_par), .en_i(en), .sclk_i(sclk),
    .sdi_i(sdi), .par_code_i(par), .code_o(code_a), .code_upd_o(upd_a),
    .sdo_o(sdo_a), .sdo_oe_o(oe_a));

  // far unit of a two-deep chain, fed by the near unit
  dly_prog_port #(.CODE_W(W)) u_dut_b (
    .clk_i(clk), .rst_ni(rst_ni), .mode_par_i(mode_par), .en_i(en), .sclk_i(sclk),
    .sdi_i(sdo_a), .par_code_i(par), .code_o(code_b), .code_upd_o(upd_b),
    .sdo_o(sdo_b), .sdo_oe_o(oe_b));

  always @(negedge clk) if (rst_ni && upd_a) upd_cnt++;

  function automatic logic [W-1:0] shift_in(logic [W-1:0] v, logic b);
    return {v[W-2:0], b};
  endfunction

  function automatic int strobes_for(logic [W-1:0] old_v, logic [W-1:0] new_v);
    return (old_v != new_v) ? 1 : 0;
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic par_write(logic [W-1:0] v);
    mode_par = 1'b1; par = v; en = 1'b1; idle(SET);
    en = 1'b0; idle(SET);
  endtask

  task automatic ser_open();
    mode_par = 1'b0; sclk = 1'b0; en = 1'b1; idle(SET);
  endtask

  task automatic ser_bit(input logic b, output logic old);
    old = sdo_a; sdi = b; idle(2);
    sclk = 1'b1; idle(SET);
    sclk = 1'b0; idle(SET);
  endtask

  task automatic ser_close();
    en = 1'b0; idle(SET);
  endtask

  task automatic ser_byte(input logic [W-1:0] v, output logic [W-1:0] old);
    for (int i = W-1; i >= 0; i--) begin
      logic o;
      ser_bit(v[i], o);
      old[i] = o;
    end
  endtask

  task automatic readback(output logic [W-1:0] got);
    ser_open();
    for (int i = W-1; i >= 0; i--) begin
      logic o;
      ser_bit(sdo_a, o);
      got[i] = o;
    end
    ser_close();
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [W-1:0] exp_code, got, v, nv;
    int u0;
    void'($urandom(32'd20240611));
    idle(3);
    // R1: reset values
    check("R1 code", code_a, 0);
    check("R1 strobe", upd_a, 0);
    check("R1 oe", oe_a, 0);
    rst_ni = 1'b1; idle(2);
    u0 = upd_cnt;
    readback(got);
    check("R1 shadow zero", got, 0);
    check("R7 readback no strobe", upd_cnt - u0, 0);
    exp_code = '0;

    // R2 / R11: bus loads, with readback of the active code
    for (int k = 0; k < 12; k++) begin
      v = W'($urandom);
      if (k == 3) v = exp_code;
      u0 = upd_cnt;
      par_write(v);
      check("R2 bus load", code_a, v);
      check("R7 bus strobe", upd_cnt - u0, strobes_for(exp_code, v));
      exp_code = v;
      if (k % 4 == 0) begin
        readback(got);
        check("R11 readback after bus", got, exp_code);
        check("R7 readback keeps code", code_a, exp_code);
      end
    end

    // R2: transparent tracking while enable stays high
    mode_par = 1'b1; en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      v = W'($urandom); par = v; idle(SET);
      check("R2 transparent", code_a, v);
    end
    en = 1'b0; idle(SET);
    exp_code = v;

    // R3: bus ignored while enable is low
    for (int k = 0; k < 4; k++) begin
      par = W'($urandom); idle(SET);
      check("R3 latched", code_a, exp_code);
    end

    // R4 R5 R6: serial writes return the old code bit 7 first
    for (int k = 0; k < 10; k++) begin
      v = W'($urandom);
      if (k == 2) v = exp_code;
      u0 = upd_cnt;
      ser_open();
      check("R6 oe high", oe_a, 1);
      ser_byte(v, got);
      check("R6 old out", got, exp_code);
      check("R4 held in transfer", code_a, exp_code);
      ser_close();
      check("R6 oe low", oe_a, 0);
      check("R5 commit", code_a, v);
      check("R7 serial strobe", upd_cnt - u0, strobes_for(exp_code, v));
      exp_code = v;
    end

    // R8: serial clock with enable low
    mode_par = 1'b0;
    for (int k = 0; k < 6; k++) begin
      sdi = 1'(~exp_code[k]); idle(2);
      sclk = 1'b1; idle(SET); sclk = 1'b0; idle(SET);
    end
    check("R8 code kept", code_a, exp_code);
    readback(got);
    check("R8 shadow kept", got, exp_code);

    // R9: seven shifts, then clock rise together with enable fall
    v = W'($urandom);
    nv = exp_code;
    ser_open();
    for (int i = W-1; i >= 1; i--) begin
      logic o;
      ser_bit(v[i], o);
      nv = shift_in(nv, v[i]);
    end
    sdi = ~v[0]; idle(2);
    en = 1'b0; sclk = 1'b1; idle(SET);
    sclk = 1'b0; idle(SET);
    check("R9 coincident fall", code_a, nv);
    exp_code = nv;

    // R10: two-unit chain, far word sent first
    v = W'($urandom); nv = W'($urandom);
    ser_open();
    ser_byte(v, got);
    ser_byte(nv, got);
    ser_close();
    check("R10 near unit", code_a, nv);
    check("R10 far unit", code_b, v);

    summary();
    $finish;
  end
endmodule